// File: doc/BRIEF.md
# Two-Cycle DMA Bus Sequencer

This block steps one DMA transfer through the bus. A transfer moves one data unit in two phases: it reads from a source address, then writes the captured unit to a destination address. The block samples a request on a rising clock edge and latches the two addresses and a target-kind flag at that edge. It then waits for bus mastership. Next it runs the read phase and the write phase, adding a wait cycle for each edge at which the external memory acknowledge is missing. It ends with a one-cycle completion pulse and returns to idle.

Targets that are on-chip peripherals or internal RAM take a shortcut. A single internal-ready cycle replaces the external read. The write phase then runs without waiting for the acknowledge. Channel arbitration, address stepping and byte counting belong to the surrounding controller.

Top module: `dma2c_bus_seq`

## Requirements
- R1: A synchronous active-high `rst` forces idle. At the first edge where it is sampled high, `rd_o`, `wr_o`, `done_o`, `addr_o` and `wdata_o` all become 0, even in the middle of a transfer.
- R2: In idle, no strobe is asserted and `addr_o` is 0. A transfer starts only when `req_i` is high at a rising edge. At that edge `src_addr_i`, `dst_addr_i` and `local_tgt_i` are latched, and later changes to those inputs have no effect on the transfer.
- R3: After a request, all outputs stay inactive until an edge with `gnt_i` high. One edge later the read phase begins: for an external target `rd_o`=1 with `addr_o` equal to the latched source, and for a local target all outputs stay inactive.
- R4: The external read phase holds `rd_o`=1 and `addr_o`=source. It has one read-start cycle, one wait cycle for each edge in read-start or read-wait at which `ack_i` is 0, and one read-last cycle.
- R5: `rdata_i` is captured at the edge that leaves read-last (external) or internal-ready (local). The captured value appears on `wdata_o` from the first write cycle and stays unchanged through the completion cycle.
- R6: For a local target, one internal-ready cycle with no strobe replaces the read phase. The write phase then takes exactly one write-start cycle and one write-last cycle whatever `ack_i` is.
- R7: The write phase holds `addr_o`=destination. `wr_o`=1 during write-start and during one wait cycle for each edge in write-start or write-wait at which `ack_i` is 0 (external target). `rd_o` and `wr_o` are never high together.
- R8: The write phase ends with exactly one write-last cycle in which `wr_o`=0 and `addr_o` is still the destination.
- R9: The cycle after write-last has `done_o`=1 for exactly one cycle with `addr_o`=0. The next cycle is idle with `wdata_o` cleared to 0.
- R10: `req_i` is ignored from the request edge until idle is re-entered. A request held high during a transfer does not start another transfer once it drops before idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | DMA transfer request |
| gnt_i | input | 1 | Bus mastership granted |
| ack_i | input | 1 | External memory acknowledge |
| local_tgt_i | input | 1 | 1 = on-chip peripheral / internal RAM target |
| src_addr_i | input | AW | Source address, latched with the request |
| dst_addr_i | input | AW | Destination address, latched with the request |
| rdata_i | input | DW | Read data bus |
| addr_o | output | AW | Bus address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wdata_o | output | DW | Write data bus |
| done_o | output | 1 | One-cycle transfer-complete pulse |

## Verification
Every output is a register loaded from the next bus state, so a wrong state transition appears at the ports one edge after the edge that caused it. It shows up as a strobe that is one cycle short or long, as the wrong address, as a missing `done_o` or one that lasts two cycles, or as a write data value taken at the wrong edge. The bench builds the expected per-cycle output trace from the wait counts and grant delays of each transfer, and compares all outputs after every edge. Any miscount of wait states or any skipped state therefore fails in the cycle where it first differs.

// File: rtl/dma2c_pkg.sv
package dma2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_READY = 4'd1,
    ST_RBEG  = 4'd2,
    ST_RWAIT = 4'd3,
    ST_RLAST = 4'd4,
    ST_RLOC  = 4'd5,
    ST_WBEG  = 4'd6,
    ST_WWAIT = 4'd7,
    ST_WLAST = 4'd8,
    ST_END   = 4'd9
  } bus_st_e;

  function automatic logic st_reads(bus_st_e s);
    return (s == ST_RBEG) || (s == ST_RWAIT) || (s == ST_RLAST);
  endfunction

  function automatic logic st_writes(bus_st_e s);
    return (s == ST_WBEG) || (s == ST_WWAIT) || (s == ST_WLAST);
  endfunction

  function automatic logic st_capture(bus_st_e s);
    return (s == ST_RLAST) || (s == ST_RLOC);
  endfunction

endpackage

// File: rtl/dma2c_fsm.sv
module dma2c_fsm
  import dma2c_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_i,
  input  logic    gnt_i,
  input  logic    ack_i,
  input  logic    local_tgt_i,
  output bus_st_e st_q,
  output bus_st_e st_d
);

  logic loc_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ST_READY;
      ST_READY: if (gnt_i) st_d = loc_q ? ST_RLOC : ST_RBEG;
      ST_RBEG:  st_d = ack_i ? ST_RLAST : ST_RWAIT;
      ST_RWAIT: if (ack_i) st_d = ST_RLAST;
      ST_RLAST: st_d = ST_WBEG;
      ST_RLOC:  st_d = ST_WBEG;
      ST_WBEG:  st_d = (ack_i || loc_q) ? ST_WLAST : ST_WWAIT;
      ST_WWAIT: if (ack_i) st_d = ST_WLAST;
      ST_WLAST: st_d = ST_END;
      ST_END:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      loc_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) loc_q <= local_tgt_i;
      else if (st_q == ST_END)      loc_q <= 1'b0;
    end
  end

  AST_RWAIT_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RWAIT) |-> !$past(ack_i)); // R4

  AST_END_AFTER_WLAST: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_END) |-> ($past(st_q) == ST_WLAST)); // R8

  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_END) |=> (st_q == ST_IDLE)); // R9

  AST_LOCAL_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    loc_q |-> (st_q != ST_WWAIT) && (st_q != ST_RBEG)); // R6

endmodule

// File: rtl/dma2c_datapath.sv
module dma2c_datapath
  import dma2c_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_st_e       st_q,
  input  bus_st_e       st_d,
  input  logic          req_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o
);

  localparam logic [AW-1:0] ADDR_IDLE = '0;
  localparam logic [DW-1:0] DATA_IDLE = '0;

  logic [AW-1:0] src_q, dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= ADDR_IDLE;
      dst_q   <= ADDR_IDLE;
      addr_o  <= ADDR_IDLE;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      done_o  <= 1'b0;
      wdata_o <= DATA_IDLE;
    end else begin
      if (st_q == ST_IDLE && req_i) begin
        src_q <= src_addr_i;
        dst_q <= dst_addr_i;
      end else if (st_q == ST_END) begin
        src_q <= ADDR_IDLE;
        dst_q <= ADDR_IDLE;
      end

      if (st_reads(st_d))       addr_o <= src_q;
      else if (st_writes(st_d)) addr_o <= dst_q;
      else                      addr_o <= ADDR_IDLE;

      rd_o   <= st_reads(st_d);
      wr_o   <= (st_d == ST_WBEG) || (st_d == ST_WWAIT);
      done_o <= (st_d == ST_END);

      if (st_capture(st_q))    wdata_o <= rdata_i;
      else if (st_q == ST_END) wdata_o <= DATA_IDLE;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o)); // R7

  AST_RD_ADDR_SRC: assert property (@(posedge clk) disable iff (rst)
    rd_o |-> (addr_o == src_q)); // R4

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> $stable(wdata_o)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

endmodule

// File: rtl/dma2c_bus_seq.sv
module dma2c_bus_seq
  import dma2c_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          gnt_i,
  input  logic          ack_i,
  input  logic          local_tgt_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o
);

  bus_st_e st_q, st_d;

  dma2c_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .gnt_i       (gnt_i),
    .ack_i       (ack_i),
    .local_tgt_i (local_tgt_i),
    .st_q        (st_q),
    .st_d        (st_d)
  );

  dma2c_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .st_q       (st_q),
    .st_d       (st_d),
    .req_i      (req_i),
    .src_addr_i (src_addr_i),
    .dst_addr_i (dst_addr_i),
    .rdata_i    (rdata_i),
    .addr_o     (addr_o),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .wdata_o    (wdata_o),
    .done_o     (done_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !rd_o && !wr_o && (addr_o == '0)); // R2

endmodule

// File: tb/dma2c_bus_seq_tb.sv
module dma2c_bus_seq_tb;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst, req_i, gnt_i, ack_i, local_tgt_i;
  logic [AW-1:0] src_addr_i, dst_addr_i, addr_o;
  logic [DW-1:0] rdata_i, wdata_o;
  logic          rd_o, wr_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma2c_bus_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .gnt_i(gnt_i), .ack_i(ack_i),
    .local_tgt_i(local_tgt_i), .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .rdata_i(rdata_i), .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o),
    .wdata_o(wdata_o), .done_o(done_o)
  );

  typedef struct {
    bit            rst, req, gnt, ack, loc;
    logic [AW-1:0] src, dst;
    logic [DW-1:0] rdata;
    logic          rd, wr, done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    string         tag;
  } step_t;

  step_t plan[$];

  function automatic void add(bit r, bit rq, bit g, bit a, bit l,
                              logic [AW-1:0] s, logic [AW-1:0] d, logic [DW-1:0] rdat,
                              logic erd, logic ewr, logic edn,
                              logic [AW-1:0] ead, logic [DW-1:0] ewd, string tag);
    step_t e;
    logic [31:0] noise;
    noise = 32'h5A3C_0000 ^ plan.size();
    e.rst = r; e.req = rq; e.gnt = g; e.ack = a; e.loc = l;
    e.src = rq ? s : noise; e.dst = rq ? d : ~noise;
    e.rdata = rdat;
    e.rd = erd; e.wr = ewr; e.done = edn; e.addr = ead; e.wdata = ewd;
    e.tag = tag;
    plan.push_back(e);
  endfunction

  // One transfer: g edges without grant, w/ww missing-ack edges, br = request noise while busy
  function automatic void xfer(bit loc, int g, int w, int ww,
                               logic [DW-1:0] dat, logic [AW-1:0] s, logic [AW-1:0] t, bit br);
    add(0, 1, 0, 0, loc, s, t, ~dat, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < g; i++) add(0, br, 0, 1, ~loc, s, t, ~dat, 0, 0, 0, 0, 0, "R3");
    if (!loc) begin
      add(0, br, 1, 0, 1, s, t, ~dat, 1, 0, 0, s, 0, "R3");
      for (int i = 0; i < w; i++) add(0, br, 1, 0, 1, s, t, ~dat, 1, 0, 0, s, 0, "R4");
      add(0, br, 1, 1, 1, s, t, ~dat, 1, 0, 0, s, 0, "R4");
      add(0, br, 1, 0, 1, s, t, dat, 0, 1, 0, t, dat, "R5");
      for (int i = 0; i < ww; i++) add(0, br, 1, 0, 0, s, t, ~dat, 0, 1, 0, t, dat, "R7");
      add(0, br, 1, 1, 0, s, t, ~dat, 0, 0, 0, t, dat, "R8");
    end else begin
      add(0, br, 1, 0, 0, s, t, ~dat, 0, 0, 0, 0, 0, "R6");
      add(0, br, 1, 0, 0, s, t, dat, 0, 1, 0, t, dat, "R6");
      add(0, br, 1, 0, 1, s, t, ~dat, 0, 0, 0, t, dat, "R6");
    end
    add(0, br, 1, 1, 1, s, t, ~dat, 0, 0, 1, 0, dat, "R9");
    add(0, 0, 0, 0, 0, s, t, ~dat, 0, 0, 0, 0, 0, "R9");
    add(0, 0, 1, 1, 1, s, t, dat, 0, 0, 0, 0, 0, "R10");
  endfunction

  initial begin
    rst = 1'b1; req_i = 1'b0; gnt_i = 1'b0; ack_i = 1'b0; local_tgt_i = 1'b0;
    src_addr_i = '0; dst_addr_i = '0; rdata_i = '0;

    // reset state (R1)
    add(1, 1, 1, 1, 1, 32'h11, 32'h22, 32'h33, 0, 0, 0, 0, 0, "R1");
    add(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // idle with grant and ack but no request stays quiet (R2)
    add(0, 0, 1, 1, 0, 0, 0, 32'h77, 0, 0, 0, 0, 0, "R2");

    xfer(0, 0, 0, 0, 32'hDEAD_BEEF, 32'h1000_0000, 32'h2000_0000, 0);
    xfer(0, 2, 3, 2, 32'h0123_4567, 32'h1000_0040, 32'h2000_0080, 0);
    xfer(1, 1, 0, 0, 32'hCAFE_F00D, 32'h0000_0400, 32'h0000_0800, 0);
    xfer(0, 1, 1, 0, 32'h89AB_CDEF, 32'h3000_0004, 32'h4000_0008, 1);
    xfer(1, 0, 0, 0, 32'h0F0F_F0F0, 32'h0000_0010, 32'h0000_0020, 1);
    xfer(0, 0, 0, 4, 32'hFFFF_0001, 32'hFFFF_FFFC, 32'h0000_0004, 0);

    // reset in the middle of a read wait (R1)
    add(0, 1, 0, 0, 0, 32'hAAAA_0000, 32'hBBBB_0000, 0, 0, 0, 0, 0, 0, "R2");
    add(0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 32'hAAAA_0000, 0, "R3");
    add(0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 32'hAAAA_0000, 0, "R4");
    add(1, 0, 1, 1, 0, 0, 0, 32'h55, 0, 0, 0, 0, 0, "R1");
    add(0, 0, 1, 1, 0, 0, 0, 32'h66, 0, 0, 0, 0, 0, "R1");
    xfer(0, 0, 2, 1, 32'h1357_9BDF, 32'h5000_0000, 32'h6000_0000, 0);

    foreach (plan[k]) begin
      @(negedge clk);
      rst = plan[k].rst; req_i = plan[k].req; gnt_i = plan[k].gnt; ack_i = plan[k].ack;
      local_tgt_i = plan[k].loc; src_addr_i = plan[k].src; dst_addr_i = plan[k].dst;
      rdata_i = plan[k].rdata;
      @(posedge clk);
      #1;
      checks++;
      if (rd_o !== plan[k].rd || wr_o !== plan[k].wr || done_o !== plan[k].done ||
          addr_o !== plan[k].addr || wdata_o !== plan[k].wdata) begin
        fails++;
        $display("FAIL %s step %0d: got rd=%b wr=%b done=%b addr=%h wdata=%h, expected rd=%b wr=%b done=%b addr=%h wdata=%h",
                 plan[k].tag, k, rd_o, wr_o, done_o, addr_o, wdata_o,
                 plan[k].rd, plan[k].wr, plan[k].done, plan[k].addr, plan[k].wdata);
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected end of plan");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule